// File: doc/BRIEF.md
# Masked 3x3 Binary Template Matcher

This block takes a binary image as a stream, one pixel per accepted beat in raster order. From it the block forms a 3x3 neighbourhood around every pixel. Two single-line delay memories supply the neighbourhood, and a small shift window holds it. The nine window pixels are compared with a programmable 9-bit template. A second 9-bit word marks positions that are "don't care". The output pixel is 1 only when every position that is not a don't-care agrees with its template bit. This is a hit-or-miss match. Erosion, dilation and pattern detection are all special cases of it.

Both streams use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The source must hold `s_valid`, `s_pix` and `s_sof` steady until the beat is accepted. The block holds `m_valid` and `m_pix` steady until the sink takes the beat. While a result waits in front of a stalled sink, `s_ready` is low, so back-pressure reaches the source directly. After the last pixel of a frame, the block pushes `IMG_W + 1` zero pixels of its own to drain the final rows, and `s_ready` stays low during that drain.

Template and don't-care words are written into shadow registers through a plain configuration write port. They are copied to the working registers on the beat that carries the frame-start flag.

Top module: `bin_hitmiss_3x3`

## Requirements
- R1: The window bit k = 3*row + col, with row 0 the line above the centre, col 0 the pixel left of the centre, and bit 4 the centre. The output for a centre is 1 exactly when every bit k has either don't-care bit k = 1 or window bit k equal to template bit k.
- R2: Window positions outside the image (above row 0, below row IMG_H-1, left of column 0, right of column IMG_W-1) take the value 0 in the comparison.
- R3: Exactly one output beat is produced per input pixel, in raster order. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_pix` stay unchanged.
- R4: `s_ready` is low whenever an output beat is pending and not being taken. After the IMG_W*IMG_H-th pixel of a frame is accepted, `s_ready` stays low for IMG_W+1 cycles while the sink is always ready.
- R5: A write with `cfg_sel` = 0 loads the template shadow and a write with `cfg_sel` = 1 loads the don't-care shadow. The shadows become active on the accepted beat with `s_sof` = 1. A frame begun without `s_sof` still uses the previous active words.
- R6: When all nine don't-care bits are 1, every output pixel is 1.
- R7: After reset, `m_valid` = 0, `s_ready` = 1, and the active template and don't-care words are both 0, so a pixel outputs 1 only when its whole (zero-padded) window is 0.
- R8: An accepted beat with `s_sof` = 1 starts a new frame at column 0 of row 0, even in the middle of a frame. Results of the interrupted frame are still delivered for every centre whose whole neighbourhood had already arrived, and no others.
- R9: With no stalls on either side, the first output of a frame becomes valid in the cycle after the (IMG_W+2)-th pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects template shadow, 1 selects don't-care shadow |
| cfg_data | input | 9 | Word written to the selected shadow |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can accept an input pixel |
| s_sof | input | 1 | Marks the first pixel of a frame |
| s_pix | input | 1 | Input binary pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Sink accepts output pixel |
| m_pix | output | 1 | Match result for the window centre |

## Verification
The bench builds the block with a 7-pixel by 5-line image. The line memories are then short, and each frame is only 35 pixels, so a run covers many whole frames. Each frame includes the drain, every border row and column including all four corners, and the column wrap from one line to the next. The odd width, which is not a power of two, exercises the column counter's wrap at a value below its natural rollover. Five lines are enough that interior centres, which see no zero padding, appear alongside border centres in every frame.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int TAPS = 9;
  localparam int CENTRE_BIT = 4;
  typedef logic [TAPS-1:0] tmpl_t;
endpackage

// File: rtl/hm_line.sv
module hm_line #(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout
);
  logic mem [DEPTH];

  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end
endmodule

// File: rtl/hm_ctrl.sv
module hm_ctrl #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  localparam int CW = $clog2(IMG_W),
  localparam int RW = $clog2(IMG_H + 2),
  localparam int FW = $clog2(IMG_W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic          s_sof,
  input  logic          m_ready,
  output logic          s_ready,
  output logic          adv,
  output logic          restart,
  output logic          flushing,
  output logic [CW-1:0] wr_col,
  output logic          win_valid,
  output logic [RW-1:0] cen_row,
  output logic [CW-1:0] cen_col
);
  logic [CW-1:0] in_col;
  logic [RW-1:0] in_row;
  logic [FW-1:0] fill;
  logic          cen_on;
  logic          hold, in_acc, last_in, flush_end, primed;

  assign hold      = win_valid && !m_ready;
  assign s_ready   = !flushing && !hold;
  assign in_acc    = s_valid && s_ready;
  assign adv       = (in_acc || flushing) && !hold;
  assign restart   = in_acc && s_sof;
  assign last_in   = in_acc && !s_sof && (in_row == RW'(IMG_H - 1)) && (in_col == CW'(IMG_W - 1));
  assign flush_end = flushing && !hold && (in_row == RW'(IMG_H + 1));
  assign primed    = (fill == FW'(IMG_W + 1));
  assign wr_col    = restart ? '0 : in_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_col   <= '0;
      in_row   <= '0;
      flushing <= 1'b0;
      fill     <= '0;
    end else begin
      if (restart) begin
        in_col <= CW'(1);
        in_row <= '0;
      end else if (flush_end) begin
        in_col <= '0;
        in_row <= '0;
      end else if (adv) begin
        if (in_col == CW'(IMG_W - 1)) begin
          in_col <= '0;
          in_row <= in_row + 1'b1;
        end else begin
          in_col <= in_col + 1'b1;
        end
      end

      if (last_in)        flushing <= 1'b1;
      else if (flush_end) flushing <= 1'b0;

      if (restart)                fill <= FW'(1);
      else if (flush_end)         fill <= '0;
      else if (adv && !primed)    fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      cen_on    <= 1'b0;
      cen_row   <= '0;
      cen_col   <= '0;
    end else if (restart) begin
      win_valid <= 1'b0;
      cen_on    <= 1'b0;
    end else if (adv && primed) begin
      win_valid <= 1'b1;
      cen_on    <= !flush_end;
      if (!cen_on) begin
        cen_row <= '0;
        cen_col <= '0;
      end else if (cen_col == CW'(IMG_W - 1)) begin
        cen_col <= '0;
        cen_row <= cen_row + 1'b1;
      end else begin
        cen_col <= cen_col + 1'b1;
      end
    end else if (adv || m_ready) begin
      win_valid <= 1'b0;
    end
  end

  AST_CENTRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !m_ready |=> win_valid && $stable(cen_row) && $stable(cen_col)); // R3
  AST_CENTRE_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (cen_row < RW'(IMG_H)) && (cen_col < CW'(IMG_W))); // R2
  AST_NO_TAKE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !in_acc && !adv); // R4
endmodule

// File: rtl/hm_window.sv
module hm_window #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  localparam int CW = $clog2(IMG_W),
  localparam int RW = $clog2(IMG_H + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          top_in,
  input  logic          mid_in,
  input  logic          bot_in,
  input  logic [RW-1:0] cen_row,
  input  logic [CW-1:0] cen_col,
  output hm_pkg::tmpl_t win
);
  logic [2:0] raw [3];
  logic [2:0] feed;
  logic at_top, at_bot, at_lft, at_rgt;

  assign feed   = {bot_in, mid_in, top_in};
  assign at_top = (cen_row == '0);
  assign at_bot = (cen_row == RW'(IMG_H - 1));
  assign at_lft = (cen_col == '0);
  assign at_rgt = (cen_col == CW'(IMG_W - 1));

  for (genvar r = 0; r < 3; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   raw[r] <= '0;
      else if (adv) raw[r] <= {feed[r], raw[r][2:1]};
    end
    for (genvar c = 0; c < 3; c++) begin : g_col
      localparam logic OUT_T = (r == 0);
      localparam logic OUT_B = (r == 2);
      localparam logic OUT_L = (c == 0);
      localparam logic OUT_R = (c == 2);
      assign win[3*r + c] = raw[r][c] &
        ~((OUT_T & at_top) | (OUT_B & at_bot) | (OUT_L & at_lft) | (OUT_R & at_rgt));
    end
  end

  AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(raw[0]) && $stable(raw[1]) && $stable(raw[2])); // R3
endmodule

// File: rtl/hm_match.sv
module hm_match (
  input  hm_pkg::tmpl_t win,
  input  hm_pkg::tmpl_t tmpl,
  input  hm_pkg::tmpl_t dont_care,
  output logic          hit
);
  hm_pkg::tmpl_t agree, pass;

  for (genvar k = 0; k < hm_pkg::TAPS; k++) begin : g_tap
    assign agree[k] = ~(win[k] ^ tmpl[k]);
    assign pass[k]  = agree[k] | dont_care[k];
  end

  assign hit = &pass;

  always_comb begin
    if (&dont_care) AST_ALL_IGNORED_HIT: assert (hit); // R6
  end
endmodule

// File: rtl/bin_hitmiss_3x3.sv
module bin_hitmiss_3x3 #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  localparam int CW = $clog2(IMG_W),
  localparam int RW = $clog2(IMG_H + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [8:0] cfg_data,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic       s_sof,
  input  logic       s_pix,
  output logic       m_valid,
  input  logic       m_ready,
  output logic       m_pix
);
  hm_pkg::tmpl_t tmpl_sh, dc_sh, tmpl_act, dc_act, win;
  logic          adv, restart, flushing, win_valid;
  logic [CW-1:0] wr_col, cen_col;
  logic [RW-1:0] cen_row;
  logic          pix_in, up1, up2, hit;

  assign pix_in = flushing ? 1'b0 : s_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmpl_sh  <= '0;
      dc_sh    <= '0;
      tmpl_act <= '0;
      dc_act   <= '0;
    end else begin
      if (cfg_we && !cfg_sel) tmpl_sh <= cfg_data;
      if (cfg_we &&  cfg_sel) dc_sh   <= cfg_data;
      if (restart) begin
        tmpl_act <= tmpl_sh;
        dc_act   <= dc_sh;
      end
    end
  end

  hm_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sof(s_sof), .m_ready(m_ready),
    .s_ready(s_ready), .adv(adv), .restart(restart), .flushing(flushing),
    .wr_col(wr_col), .win_valid(win_valid), .cen_row(cen_row), .cen_col(cen_col)
  );

  hm_line #(.DEPTH(IMG_W)) line_near_i (
    .clk(clk), .wr_en(adv), .addr(wr_col), .din(pix_in), .dout(up1)
  );

  hm_line #(.DEPTH(IMG_W)) line_far_i (
    .clk(clk), .wr_en(adv), .addr(wr_col), .din(up1), .dout(up2)
  );

  hm_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) window_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .top_in(up2), .mid_in(up1), .bot_in(pix_in),
    .cen_row(cen_row), .cen_col(cen_col), .win(win)
  );

  hm_match match_i (.win(win), .tmpl(tmpl_act), .dont_care(dc_act), .hit(hit));

  assign m_valid = win_valid;
  assign m_pix   = hit;

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_pix)); // R3
  AST_ACTIVE_ONLY_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(tmpl_act) && $stable(dc_act)); // R5
  AST_FULL_DONT_CARE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && (&dc_act) |-> m_pix); // R6
endmodule

// File: tb/bin_hitmiss_3x3_tb_top.sv
`timescale 1ns/1ps
module bin_hitmiss_3x3_tb_top;
  localparam int TW = 7;
  localparam int TH = 5;
  localparam int NPIX = TW * TH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [8:0] cfg_data = '0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_pix = 1'b0, m_ready = 1'b0;
  logic s_ready, m_valid, m_pix;

  int n_tests = 0;
  int n_fail = 0;
  bit fr [NPIX];
  logic [8:0] e_tmpl = '0, e_dc = '0;

  always #2.5 clk = ~clk;

  bin_hitmiss_3x3 #(.IMG_W(TW), .IMG_H(TH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_pix(s_pix),
    .m_valid(m_valid), .m_ready(m_ready), .m_pix(m_pix)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit px(input int r, input int c);
    if (r < 0 || r >= TH || c < 0 || c >= TW) return 1'b0;
    return fr[r*TW + c];
  endfunction

  function automatic bit exp_out(input int k);
    int r, c;
    r = k / TW;
    c = k % TW;
    for (int dr = 0; dr < 3; dr++)
      for (int dc = 0; dc < 3; dc++) begin
        int b;
        b = dr*3 + dc;
        if (!e_dc[b] && (px(r+dr-1, c+dc-1) != e_tmpl[b])) return 1'b0;
      end
    return 1'b1;
  endfunction

  function automatic string tag_for(input int k, input string forced);
    int r, c;
    if (forced != "") return forced;
    if (&e_dc) return "R6";
    r = k / TW;
    c = k % TW;
    if (r == 0 || r == TH-1 || c == 0 || c == TW-1) return "R2";
    return "R1";
  endfunction

  task automatic cfg_write(input bit sel, input logic [8:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill_frame(input int dens);
    for (int i = 0; i < NPIX; i++) fr[i] = (($urandom % 100) < dens);
  endtask

  task automatic run_frame(input int npix, input bit sof, input int vpct, input int rpct,
                           input string forced);
    int idx, got, nexp, cyc, first_acc, flush_lo;
    bit acc_last, prev_hold, prev_pix, seen_valid, flush_done, directed;
    idx = 0; got = 0; cyc = 0; first_acc = -1; flush_lo = 0;
    acc_last = 1'b1; prev_hold = 1'b0; prev_pix = 1'b0; seen_valid = 1'b0; flush_done = 1'b0;
    directed = (vpct == 100) && (rpct == 100) && (npix == NPIX);
    nexp = (npix == NPIX) ? NPIX : npix - TW - 1;
    while ((got < nexp || idx < npix) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (acc_last || !s_valid) s_valid = (idx < npix) && (($urandom % 100) < vpct);
      s_pix   = (idx < npix) ? fr[idx] : 1'b0;
      s_sof   = sof && (idx == 0);
      m_ready = (($urandom % 100) < rpct);
      #1;
      if (prev_hold)
        check(m_valid && (m_pix == prev_pix), "R3", int'(m_pix), int'(prev_pix));
      if (m_valid && !m_ready)
        check(!s_ready, "R4", int'(s_ready), 0);
      if (m_valid && !seen_valid) begin
        seen_valid = 1'b1;
        first_acc = idx;
      end
      if (directed && idx == npix && !flush_done) begin
        if (!s_ready) flush_lo++;
        else flush_done = 1'b1;
      end
      if (m_valid && m_ready) begin
        if (got < nexp) begin
          bit e;
          e = exp_out(got);
          check(m_pix == e, tag_for(got, forced), int'(m_pix), int'(e));
        end else begin
          check(1'b0, "R3", got + 1, nexp);
        end
        got++;
      end
      prev_hold = m_valid && !m_ready;
      prev_pix  = m_pix;
      acc_last  = s_valid && s_ready;
      if (acc_last) idx++;
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; m_ready = 1'b1;
    check(got == nexp, "R3", got, nexp);
    if (directed) begin
      check(first_acc == TW + 2, "R9", first_acc, TW + 2);
      check(flush_lo == TW + 1, "R4", flush_lo, TW + 1);
    end
    for (int i = 0; i < 3; i++) begin
      #1;
      if (npix == NPIX) check(!m_valid, "R3", int'(m_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    check(!m_valid, "R7", int'(m_valid), 0);
    check(s_ready, "R7", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset words (all zero) in force for a frame without frame start
    fill_frame(15);
    e_tmpl = '0; e_dc = '0;
    run_frame(NPIX, 1'b0, 100, 100, "R7");

    // R2: all-ones image against all-ones template, borders must miss
    for (int i = 0; i < NPIX; i++) fr[i] = 1'b1;
    cfg_write(1'b0, 9'h1FF);
    e_tmpl = 9'h1FF; e_dc = '0;
    run_frame(NPIX, 1'b1, 70, 60, "");

    // R5: new don't-care word not applied without frame start
    cfg_write(1'b1, 9'h1FF);
    fill_frame(50);
    run_frame(NPIX, 1'b0, 80, 80, "R5");
    // R6: applied at frame start, all positions ignored
    e_dc = 9'h1FF;
    fill_frame(50);
    run_frame(NPIX, 1'b1, 60, 50, "R6");

    // R8: interrupted frame followed by a restart
    cfg_write(1'b0, 9'h0F0);
    cfg_write(1'b1, 9'h10B);
    e_tmpl = 9'h0F0; e_dc = 9'h10B;
    fill_frame(50);
    run_frame(2*TW + 3, 1'b1, 90, 70, "R8");
    fill_frame(50);
    run_frame(NPIX, 1'b1, 75, 75, "R8");

    // R1: random templates and stream timing
    for (int f = 0; f < 8; f++) begin
      logic [8:0] t, d;
      t = 9'($urandom);
      d = 9'($urandom) | 9'($urandom);
      cfg_write(1'b0, t);
      cfg_write(1'b1, d);
      e_tmpl = t; e_dc = d;
      fill_frame(20 + 10*f);
      run_frame(NPIX, 1'b1, 30 + ($urandom % 71), 30 + ($urandom % 71), "");
    end

    // R9 and R4 directed at full rate with a fresh pattern
    cfg_write(1'b0, 9'h010);
    cfg_write(1'b1, 9'h000);
    e_tmpl = 9'h010; e_dc = '0;
    fill_frame(10);
    fr[2*TW + 3] = 1'b1;
    run_frame(NPIX, 1'b1, 100, 100, "");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule